// File: doc/BRIEF.md
# Sample FIFO with Host Bus Port

This block holds 12-bit twos-complement conversion results in an eight-word FIFO. A host processor reaches the FIFO through a parallel bus with chip select, write strobe, read strobe and a single address line. With the address line low, a read returns the oldest stored word. With it high, a read returns a status word. With it high, a write loads the control fields. A read of the FIFO head pops that word when the read strobe is released.

A rising edge on the asynchronous convert-start input is synchronised to the clock. It launches one conversion. The active-low busy output is low during the hold phase of that conversion. At the end of the conversion, a counter-based converter model pushes its next result into the FIFO.

An active-low almost-full output compares the stored word count with a programmed threshold. It is re-evaluated at each end of conversion and on each head read. A control bit can force it inactive. A second control bit decides whether the bus drivers may be enabled while busy is low.

Top module: `sample_fifo_host`

## Requirements
- R1: After reset, busy_n and almost_full_n are 1 and host_oe is 0. A status read returns 0x040: count 0, empty, all control fields cleared. A head read returns 0x800.
- R2: A read with addr_sel=0 returns the FIFO head. A read with addr_sel=1 returns the status word, with these fields: [2:0] low bits of the word count, [3] full (8 words), [4] sticky overflow, [5] read-while-busy enable, [6] empty, [7] zero, [10:8] threshold field, [11] busy.
- R3: The control fields load from host_din only in a clock cycle where cs_n=0, wr_n=0 and addr_sel=1. host_din[2:0] loads the threshold field and host_din[5] loads the read-while-busy enable. A write with addr_sel=0, or with cs_n=1, leaves both fields unchanged.
- R4: host_oe is 1 exactly when cs_n=0, rd_n=0, and either busy_n=1 or the read-while-busy enable is 1.
- R5: Suppose conv_start rises before clock edge k. Then busy_n is low after edge k+2 and stays low for HOLD_CYC cycles. A rising edge on conv_start while a conversion is running starts no second conversion.
- R6: The n-th conversion after reset (n = 1, 2, ...) yields n*STEP modulo 4096. The result is pushed HOLD_CYC+CONV_CYC cycles after busy_n falls.
- R7: The FIFO is released in arrival order. Each head read (addr_sel=0) removes one word at the clock edge after its read strobe is released.
- R8: A result that arrives while 8 words are stored is dropped. It sets status bit 4, and that bit stays set until reset.
- R9: A head read with the FIFO empty returns the last word removed (0x800 if none since reset). The count stays 0.
- R10: At each end of conversion, almost_full_n becomes 0 if the count after the push is at least the threshold level, and 1 otherwise. A threshold field of 1 to 7 sets a level of that many words; a field of 0 sets a level of 8.
- R11: A head read that leaves the count below the threshold level sets almost_full_n to 1. A head read that leaves the count at or above the level leaves it unchanged.
- R12: A control write with host_din[7]=1 sets almost_full_n to 1. That bit is not stored: status bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Asynchronous convert start; a rising edge starts a conversion |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_sel | input | 1 | 0 selects the FIFO head, 1 selects status/control |
| host_din | input | 8 | Control write data |
| host_dout | output | 12 | Read data, head word or status word |
| host_oe | output | 1 | Drive enable for the external tri-state bus buffer |
| busy_n | output | 1 | Low during the hold phase of a conversion |
| almost_full_n | output | 1 | Low when the count has reached the programmed threshold |

## Verification
host_dout and host_oe are combinational from the strobes and registered state. The bench samples them one cycle after it drives the strobes, at a falling clock edge. A pop, a control write and a flag forced by a control write all take effect at the first rising edge after the strobe change, so the bench reads their effects at the next falling edge. For conversions, busy_n is checked at the falling edge after rising edge k+1 (still high) and after edges k+2 through k+2+HOLD_CYC. The bench updates its model of the count, the flag and the overflow only after edge k+2+HOLD_CYC+CONV_CYC, when the push is due. It then confirms those values through almost_full_n and a status read.

// File: rtl/sfh_pkg.sv
`timescale 1ns/1ps
package sfh_pkg;
    localparam int WORD_W        = 12;
    localparam int PTR_W         = 3;
    localparam int DEPTH         = 1 << PTR_W;
    localparam int CNT_W         = PTR_W + 1;
    localparam int HOST_IN_W     = 8;
    localparam int CTL_ALLOW_BIT = 5;
    localparam int CTL_FORCE_BIT = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    localparam word_t FILL_WORD = word_t'(1) << (WORD_W - 1);

    typedef enum logic [1:0] {
        CV_IDLE = 2'd0,
        CV_HOLD = 2'd1,
        CV_CONV = 2'd2
    } conv_state_e;

    typedef struct packed {
        ptr_t thr;
        logic allow_busy_rd;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        ptr_t thr;
        logic rsvd;
        logic empty;
        logic allow_busy_rd;
        logic overflow;
        logic full;
        ptr_t cnt_lo;
    } status_t;

    function automatic cnt_t thr_level(ptr_t field);
        return (field == '0) ? cnt_t'(DEPTH) : cnt_t'(field);
    endfunction

    function automatic word_t pack_status(logic busy, ctrl_t c, cnt_t cnt, logic ovf);
        status_t s;
        s.busy          = busy;
        s.thr           = c.thr;
        s.rsvd          = 1'b0;
        s.empty         = (cnt == '0);
        s.allow_busy_rd = c.allow_busy_rd;
        s.overflow      = ovf;
        s.full          = (cnt == cnt_t'(DEPTH));
        s.cnt_lo        = cnt[PTR_W-1:0];
        return word_t'(s);
    endfunction
endpackage

// File: rtl/sfh_start_sync.sv
`timescale 1ns/1ps
module sfh_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R5: one edge yields a single-cycle start request
    p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/sfh_conv_model.sv
`timescale 1ns/1ps
module sfh_conv_model import sfh_pkg::*; #(
    parameter int    HOLD_CYC = 4,
    parameter int    CONV_CYC = 10,
    parameter word_t STEP     = 12'h155
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_rise,
    output logic  busy,
    output logic  eoc,
    output word_t result
);
    localparam int LONGEST = (HOLD_CYC > CONV_CYC) ? HOLD_CYC : CONV_CYC;
    localparam int CYC_W   = $clog2(LONGEST + 1);

    conv_state_e      st;
    logic [CYC_W-1:0] cyc;
    word_t            acc;
    logic             last_cyc;

    assign last_cyc = (st == CV_HOLD) ? (cyc == CYC_W'(HOLD_CYC - 1))
                                      : (cyc == CYC_W'(CONV_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CV_IDLE;
            cyc <= '0;
            acc <= '0;
        end else begin
            case (st)
                CV_IDLE: begin
                    cyc <= '0;
                    if (start_rise) st <= CV_HOLD;
                end
                CV_HOLD: begin
                    if (last_cyc) begin
                        st  <= CV_CONV;
                        cyc <= '0;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                CV_CONV: begin
                    if (last_cyc) begin
                        st  <= CV_IDLE;
                        cyc <= '0;
                        acc <= acc + STEP;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                default: st <= CV_IDLE;
            endcase
        end
    end

    assign busy   = (st == CV_HOLD);
    assign eoc    = (st == CV_CONV) && last_cyc;
    assign result = acc + STEP;

    // R5: busy only begins on a synchronised start edge
    p_busy_from_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_rise));
    // R6: the hold phase always hands over to conversion
    p_hold_to_conv_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (st == CV_CONV));
    // R6: end of conversion returns to idle without busy
    p_eoc_to_idle_r6: assert property (@(posedge clk) disable iff (rst)
        eoc |=> (!busy && !eoc));
endmodule

// File: rtl/sfh_fifo.sv
`timescale 1ns/1ps
module sfh_fifo import sfh_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t push_word,
    input  logic  pop,
    output word_t head,
    output cnt_t  count,
    output cnt_t  count_nxt,
    output logic  overflow
);
    word_t mem [DEPTH];
    ptr_t  wp, rp;
    cnt_t  cnt_q;
    word_t last_q;
    logic  ovf_q;
    logic  full, empty, accept, take;

    assign full      = (cnt_q == cnt_t'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign accept    = push && (!full || pop);
    assign take      = pop && !empty;
    assign count_nxt = cnt_q + cnt_t'(accept) - cnt_t'(take);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= FILL_WORD;
            wp     <= '0;
            rp     <= '0;
            cnt_q  <= '0;
            last_q <= FILL_WORD;
            ovf_q  <= 1'b0;
        end else begin
            if (accept) begin
                mem[wp] <= push_word;
                wp      <= wp + 1'b1;
            end
            if (take) begin
                rp     <= rp + 1'b1;
                last_q <= mem[rp];
            end
            cnt_q <= count_nxt;
            if (push && !accept) ovf_q <= 1'b1;
        end
    end

    assign head     = empty ? last_q : mem[rp];
    assign count    = cnt_q;
    assign overflow = ovf_q;

    // R7: the count never passes the depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cnt_t'(DEPTH));
    // R8: a dropped result raises the overflow flag
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> overflow);
    // R8: overflow is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    // R9: popping an empty FIFO keeps it empty
    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/sfh_host_port.sv
`timescale 1ns/1ps
module sfh_host_port import sfh_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic                 rd_n,
    input  logic                 addr_sel,
    input  logic [HOST_IN_W-1:0] din,
    input  logic                 busy,
    output ctrl_t                ctrl,
    output logic                 force_flag,
    output logic                 pop,
    output logic                 drive_en
);
    logic  rd_act, wr_act, rd_act_q, rd_sel_q;
    ctrl_t ctrl_q;
    logic  unused_din_bits;

    assign rd_act = !cs_n && !rd_n;
    assign wr_act = !cs_n && !wr_n && addr_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            rd_sel_q <= 1'b0;
            ctrl_q   <= '0;
        end else begin
            rd_act_q <= rd_act;
            if (rd_act) rd_sel_q <= addr_sel;
            if (wr_act) begin
                ctrl_q.thr           <= din[PTR_W-1:0];
                ctrl_q.allow_busy_rd <= din[CTL_ALLOW_BIT];
            end
        end
    end

    assign ctrl       = ctrl_q;
    assign pop        = rd_act_q && !rd_act && !rd_sel_q;
    assign force_flag = wr_act && din[CTL_FORCE_BIT];
    assign drive_en   = rd_act && (!busy || ctrl_q.allow_busy_rd);

    assign unused_din_bits = ^{din[CTL_FORCE_BIT-1], din[CTL_ALLOW_BIT-1:PTR_W]};

    // R3: control changes only after a qualified write
    p_ctrl_write_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(wr_act));
    // R7: a pop follows the end of a read access
    p_pop_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> ($past(rd_act) && !rd_act));
endmodule

// File: rtl/sample_fifo_host.sv
`timescale 1ns/1ps
module sample_fifo_host import sfh_pkg::*; #(
    parameter int    HOLD_CYC    = 4,
    parameter int    CONV_CYC    = 10,
    parameter word_t STEP        = 12'h155,
    parameter int    SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 conv_start,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic                 rd_n,
    input  logic                 addr_sel,
    input  logic [HOST_IN_W-1:0] host_din,
    output logic [WORD_W-1:0]    host_dout,
    output logic                 host_oe,
    output logic                 busy_n,
    output logic                 almost_full_n
);
    logic  start_rise, busy, eoc, pop, force_flag, ovf;
    word_t result, head;
    cnt_t  count, count_nxt, level;
    ctrl_t ctrl;
    logic  af_n_q, af_n_nxt;

    sfh_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(conv_start), .rise(start_rise)
    );

    sfh_conv_model #(.HOLD_CYC(HOLD_CYC), .CONV_CYC(CONV_CYC), .STEP(STEP)) u_conv (
        .clk(clk), .rst(rst), .start_rise(start_rise),
        .busy(busy), .eoc(eoc), .result(result)
    );

    sfh_fifo u_fifo (
        .clk(clk), .rst(rst), .push(eoc), .push_word(result), .pop(pop),
        .head(head), .count(count), .count_nxt(count_nxt), .overflow(ovf)
    );

    sfh_host_port u_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr_sel(addr_sel), .din(host_din), .busy(busy),
        .ctrl(ctrl), .force_flag(force_flag), .pop(pop), .drive_en(host_oe)
    );

    assign level = thr_level(ctrl.thr);

    always_comb begin
        af_n_nxt = af_n_q;
        if (eoc)                           af_n_nxt = !(count_nxt >= level);
        else if (pop && count_nxt < level) af_n_nxt = 1'b1;
        if (force_flag)                    af_n_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) af_n_q <= 1'b1;
        else     af_n_q <= af_n_nxt;
    end

    assign almost_full_n = af_n_q;
    assign busy_n        = !busy;
    assign host_dout     = addr_sel ? pack_status(busy, ctrl, count, ovf) : head;

    // R10: the flag only goes active at an end of conversion
    p_flag_fall_eoc_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(almost_full_n) |-> $past(eoc));
    // R11: the flag clears only through a conversion, a read or a forced write
    p_flag_rise_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(almost_full_n) |-> $past(eoc || pop || force_flag));
    // R4: the drivers never enable without both strobes
    p_oe_strobes_r4: assert property (@(posedge clk) disable iff (rst)
        host_oe |-> (!cs_n && !rd_n));
endmodule

// File: tb/sample_fifo_host_tb.sv
`timescale 1ns/1ps
module sample_fifo_host_tb;
    localparam int          HOLD_CYC = 4;
    localparam int          CONV_CYC = 10;
    localparam logic [11:0] STEP     = 12'h155;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_start = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, addr_sel = 1'b0;
    logic [7:0]  host_din = '0;
    logic [11:0] host_dout;
    logic        host_oe, busy_n, almost_full_n;

    int n_run = 0, n_fail = 0;

    logic [11:0] q[$];
    logic [11:0] last_w = 12'h800;
    logic        m_ovf = 1'b0, m_afn = 1'b1, m_allow = 1'b0;
    logic [2:0]  m_thr = 3'd0;
    int          n_conv = 0;

    always #2 clk = ~clk;

    sample_fifo_host #(.HOLD_CYC(HOLD_CYC), .CONV_CYC(CONV_CYC), .STEP(STEP)) u_dut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .addr_sel(addr_sel), .host_din(host_din), .host_dout(host_dout),
        .host_oe(host_oe), .busy_n(busy_n), .almost_full_n(almost_full_n)
    );

    function automatic int level();
        return (m_thr == 3'd0) ? 8 : int'(m_thr);
    endfunction

    function automatic logic [11:0] exp_status();
        int c;
        c = q.size();
        return {1'b0, m_thr, 1'b0, (c == 0), m_allow, m_ovf, (c == 8), 3'(c)};
    endfunction

    task automatic chk(string tag, logic [11:0] got, logic [11:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_read(logic a, output logic [11:0] d, output logic oe);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr_sel = a;
        @(negedge clk); d = host_dout; oe = host_oe;
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_head(string tag);
        logic [11:0] d, e;
        logic oe;
        e = (q.size() > 0) ? q[0] : last_w;
        bus_read(1'b0, d, oe);
        chk(tag, d, e);
        chk({tag, " oe"}, {11'd0, oe}, 12'd1);
        if (q.size() > 0) last_w = q.pop_front();
        if (q.size() < level()) m_afn = 1'b1;
        chk({tag, " R11 flag"}, {11'd0, almost_full_n}, {11'd0, m_afn});
    endtask

    task automatic read_status(string tag);
        logic [11:0] d;
        logic oe;
        bus_read(1'b1, d, oe);
        chk(tag, d, exp_status());
    endtask

    task automatic bus_write(logic csn, logic wrn, logic a, logic [7:0] v);
        @(negedge clk); cs_n = csn; wr_n = wrn; addr_sel = a; host_din = v;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        if (!csn && !wrn && a) begin
            m_thr = v[2:0]; m_allow = v[5];
            if (v[7]) m_afn = 1'b1;
        end
        chk("R12 flag after write", {11'd0, almost_full_n}, {11'd0, m_afn});
    endtask

    // mode 0: plain, 1: retrigger during conversion, 2: probe drivers while busy
    task automatic run_conv(int mode);
        @(negedge clk); conv_start = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); chk("R5 busy before", {11'd0, busy_n}, 12'd1);
        @(posedge clk);
        @(negedge clk); chk("R5 busy low", {11'd0, busy_n}, 12'd0);
        for (int i = 0; i < HOLD_CYC - 1; i++) begin
            @(negedge clk);
            chk("R5 busy held", {11'd0, busy_n}, 12'd0);
            if (mode == 2 && i == 0) begin
                cs_n = 1'b0; rd_n = 1'b0; addr_sel = 1'b1;
            end
            if (mode == 2 && i == 1) begin
                chk("R4 oe during busy", {11'd0, host_oe}, {11'd0, m_allow});
                cs_n = 1'b1; rd_n = 1'b1;
            end
        end
        @(negedge clk); chk("R5 busy released", {11'd0, busy_n}, 12'd1);
        conv_start = 1'b0;
        for (int i = 0; i < CONV_CYC; i++) begin
            @(negedge clk);
            if (mode == 1 && i == 1) conv_start = 1'b1;
            if (mode == 1 && i == 3) conv_start = 1'b0;
        end
        n_conv++;
        if (q.size() < 8) q.push_back(12'(n_conv * int'(STEP)));
        else m_ovf = 1'b1;
        m_afn = !(q.size() >= level());
        chk("R10 flag at eoc", {11'd0, almost_full_n}, {11'd0, m_afn});
        repeat (6) @(negedge clk);
        chk("R5 no second start", {11'd0, busy_n}, 12'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 got=hung exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] d;
        logic oe;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        chk("R1 busy_n", {11'd0, busy_n}, 12'd1);
        chk("R1 almost_full_n", {11'd0, almost_full_n}, 12'd1);
        chk("R1 oe idle", {11'd0, host_oe}, 12'd0);
        read_status("R1 status");
        chk("R1 status value", exp_status(), 12'h040);
        read_head("R1 R9 head after reset");

        bus_write(1'b0, 1'b0, 1'b0, 8'h27);
        bus_write(1'b1, 1'b0, 1'b1, 8'h27);
        read_status("R3 ignored writes");
        bus_write(1'b0, 1'b0, 1'b1, 8'h03);
        read_status("R2 R3 status after write");

        run_conv(1);
        read_status("R5 R6 one word after retrigger");
        run_conv(0);
        run_conv(0);
        chk("R10 flag low at 3", {11'd0, almost_full_n}, 12'd0);
        read_head("R6 R7 first word");
        read_head("R6 R7 second word");

        bus_write(1'b0, 1'b0, 1'b1, 8'h01);
        run_conv(0);
        read_head("R7 R11 pop keeps flag low");
        chk("R11 flag still low", {11'd0, almost_full_n}, 12'd0);
        bus_write(1'b0, 1'b0, 1'b1, 8'h81);
        read_status("R12 force bit not stored");

        bus_write(1'b0, 1'b0, 1'b1, 8'h00);
        while (q.size() < 8) run_conv(0);
        chk("R10 flag at level 8", {11'd0, almost_full_n}, 12'd0);
        run_conv(0);
        read_status("R8 overflow set");

        run_conv(2);
        bus_write(1'b0, 1'b0, 1'b1, 8'h20);
        run_conv(2);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; addr_sel = 1'b0;
        @(negedge clk); chk("R4 no oe without cs", {11'd0, host_oe}, 12'd0);
        rd_n = 1'b1;
        @(negedge clk);

        while (q.size() > 0) read_head("R7 drain order");
        read_head("R9 empty read 1");
        read_head("R9 empty read 2");
        read_status("R8 R9 sticky overflow, count 0");

        for (int k = 0; k < 40; k++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0, 1, 2: run_conv(int'($urandom % 3));
                3, 4:    read_head("R7 random head");
                5:       read_status("R2 random status");
                6:       bus_write(1'b0, 1'b0, 1'b1, 8'($urandom));
                default: begin
                    if ($urandom % 2 == 0) bus_write(1'b0, 1'b0, 1'b0, 8'($urandom));
                    else                   bus_write(1'b1, 1'b0, 1'b1, 8'($urandom));
                    read_status("R3 random ignored write");
                end
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule